// File: doc/BRIEF.md
# Address-Space Page Flush Scanner

This block is a sequential walker that finds every translation entry owned by one address space. A start request supplies an 8-bit address-space tag. The block then steps through all entries of the instruction translation buffer and then all entries of the data translation buffer. For every entry that belongs to that tag, it produces a page-invalidate request that carries the virtual page base address of the entry.

The translation storage stays outside the block. The scanner drives an entry select (buffer, way, index) on a read port. The storage answers in the same cycle with the decoded fields of that entry: virtual page number, owner tag, global flag and valid flag. Invalidate requests leave through a valid/ready stream. The block does not change any entry. It only reports which pages must be dropped, and it pulses a done flag once the walk is over and the last request has been accepted.

Top module: `pidflush_scan`

## Requirements
- R1: After reset `busy_o`, `done_o`, `rd_en_o` and `inv_valid_o` are all low, and they stay low while the block is idle.
- R2: An entry qualifies when `ent_valid_i` is 1, `ent_global_i` is 0 and `ent_pid_i` equals the tag captured from `pid_i` at start. Every other entry is skipped and emits nothing.
- R3: The entry select `{rd_tlb_o, rd_way_o, rd_idx_o}` counts up from 0 to 127. Buffer 0 (instruction) comes before buffer 1 (data), ways run 0 to 3 within a buffer, and indices run 0 to 15 within a way. `rd_en_o` is high exactly in the cycles where the presented entry is consumed.
- R4: The emitted `inv_addr_o` is `ent_vpn_i` shifted left by 13, so bits 12:0 are zero. Requests leave in scan order.
- R5: The block consumes one entry per cycle while its output slot is free or being accepted.
- R6: While `inv_valid_o` is high and `inv_ready_i` is low, no entry is consumed, and `inv_valid_o` and `inv_addr_o` hold their values.
- R7: A start pulse while busy is ignored. The tag in use and the emitted stream are unchanged.
- R8: `done_o` is a one-cycle pulse that appears in the cycle after the last entry is consumed and the last request is accepted. `busy_o` drops in that same cycle.
- R9: A scan that finds no qualifying entry keeps `busy_o` high for exactly 128 cycles, consumes exactly 128 entries and emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| pid_i | input | 8 | Address-space tag to flush |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_en_o | output | 1 | Presented entry is consumed this cycle |
| rd_tlb_o | output | 1 | Buffer select, 0 instruction, 1 data |
| rd_way_o | output | 2 | Way select |
| rd_idx_o | output | 4 | Index select |
| ent_vpn_i | input | 19 | Virtual page number of the selected entry |
| ent_pid_i | input | 8 | Owner tag of the selected entry |
| ent_global_i | input | 1 | Entry is shared by all address spaces |
| ent_valid_i | input | 1 | Entry holds a live mapping |
| inv_valid_o | output | 1 | Invalidate request valid |
| inv_ready_i | input | 1 | Downstream accepts the request |
| inv_addr_o | output | 32 | Virtual page base address to invalidate |

## Verification
The properties assume a combinational read port: the entry fields must belong to the select that is driven in the same cycle. The properties also assume that the storage does not change during a walk. The bench reads the entry fields from a fixed table indexed by the select lines, and it rewrites that table only between scans. The bench drives `inv_ready_i` freely, using steady, alternating and pseudo-random patterns, because the design must tolerate any back-pressure. It raises `start_i` while idle, except in the one case that tests a start pulse during a scan.

// File: rtl/pidflush_pkg.sv
package pidflush_pkg;

    localparam int PID_W      = 8;
    localparam int WORD_W     = 32;
    localparam int PAGE_SHIFT = 13;
    localparam int VPN_W      = WORD_W - PAGE_SHIFT;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_DRAIN = 2'd2
    } scan_state_e;

    typedef struct packed {
        scan_state_e          st;
        logic [PID_W-1:0]     pid;
        logic                 out_vld;
        logic [WORD_W-1:0]    out_addr;
        logic                 done;
    } scan_ctl_t;

endpackage

// File: rtl/pidflush_walker.sv
module pidflush_walker #(
    parameter int TOTAL = 128,
    localparam int PTR_W = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             advance_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic             last_o
);

    logic [PTR_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (clear_i) begin
            ptr_d = '0;
        end else if (advance_i && !last_o) begin
            ptr_d = ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr_o  = ptr_q;
    assign last_o = (ptr_q == PTR_W'(TOTAL - 1));

endmodule

// File: rtl/pidflush_match.sv
module pidflush_match
    import pidflush_pkg::*;
(
    input  logic [VPN_W-1:0]  vpn_i,
    input  logic [PID_W-1:0]  ent_pid_i,
    input  logic              global_i,
    input  logic              valid_i,
    input  logic [PID_W-1:0]  want_pid_i,
    output logic              hit_o,
    output logic [WORD_W-1:0] page_o
);

    always_comb begin
        hit_o  = valid_i && !global_i && (ent_pid_i == want_pid_i);
        page_o = {vpn_i, {PAGE_SHIFT{1'b0}}};
    end

endmodule

// File: rtl/pidflush_scan.sv
module pidflush_scan
    import pidflush_pkg::*;
#(
    parameter int NUM_TLB  = 2,
    parameter int NUM_WAYS = 4,
    parameter int NUM_IDX  = 16,
    localparam int TLB_W = (NUM_TLB  > 1) ? $clog2(NUM_TLB)  : 1,
    localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int IDX_W = (NUM_IDX  > 1) ? $clog2(NUM_IDX)  : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PID_W-1:0]  pid_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              rd_en_o,
    output logic [TLB_W-1:0]  rd_tlb_o,
    output logic [WAY_W-1:0]  rd_way_o,
    output logic [IDX_W-1:0]  rd_idx_o,
    input  logic [VPN_W-1:0]  ent_vpn_i,
    input  logic [PID_W-1:0]  ent_pid_i,
    input  logic              ent_global_i,
    input  logic              ent_valid_i,
    output logic              inv_valid_o,
    input  logic              inv_ready_i,
    output logic [WORD_W-1:0] inv_addr_o
);

    localparam int TOTAL = NUM_TLB * NUM_WAYS * NUM_IDX;
    localparam int PTR_W = (TOTAL > 1) ? $clog2(TOTAL) : 1;

    scan_ctl_t ctl_d, ctl_q;

    logic              slot_free;
    logic              visit;
    logic              last;
    logic              hit;
    logic [WORD_W-1:0] page;
    logic [PTR_W-1:0]  ptr;

    pidflush_walker #(.TOTAL(TOTAL)) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (ctl_q.st == ST_IDLE),
        .advance_i (visit),
        .ptr_o     (ptr),
        .last_o    (last)
    );

    pidflush_match u_match (
        .vpn_i      (ent_vpn_i),
        .ent_pid_i  (ent_pid_i),
        .global_i   (ent_global_i),
        .valid_i    (ent_valid_i),
        .want_pid_i (ctl_q.pid),
        .hit_o      (hit),
        .page_o     (page)
    );

    assign slot_free = !ctl_q.out_vld || inv_ready_i;
    assign visit     = (ctl_q.st == ST_SCAN) && slot_free;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (ctl_q.out_vld && inv_ready_i) begin
            ctl_d.out_vld = 1'b0;
        end
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st  = ST_SCAN;
                    ctl_d.pid = pid_i;
                end
            end
            ST_SCAN: begin
                if (visit) begin
                    if (hit) begin
                        ctl_d.out_vld  = 1'b1;
                        ctl_d.out_addr = page;
                    end
                    if (last) begin
                        if (hit) begin
                            ctl_d.st = ST_DRAIN;
                        end else begin
                            ctl_d.st   = ST_IDLE;
                            ctl_d.done = 1'b1;
                        end
                    end
                end
            end
            ST_DRAIN: begin
                if (slot_free) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, pid: '0, out_vld: 1'b0, out_addr: '0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o      = (ctl_q.st != ST_IDLE);
    assign done_o      = ctl_q.done;
    assign rd_en_o     = visit;
    assign rd_tlb_o    = ptr[PTR_W-1 -: TLB_W];
    assign rd_way_o    = ptr[IDX_W +: WAY_W];
    assign rd_idx_o    = ptr[IDX_W-1:0];
    assign inv_valid_o = ctl_q.out_vld;
    assign inv_addr_o  = ctl_q.out_addr;

endmodule

// File: rtl/pidflush_scan_chk.sv
module pidflush_scan_chk #(
    parameter int TLB_W = 1,
    parameter int WAY_W = 2,
    parameter int IDX_W = 4,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic              rd_en_o,
    input logic [TLB_W-1:0]  rd_tlb_o,
    input logic [WAY_W-1:0]  rd_way_o,
    input logic [IDX_W-1:0]  rd_idx_o,
    input logic              inv_valid_o,
    input logic              inv_ready_i,
    input logic [ADDR_W-1:0] inv_addr_o
);

    localparam int SEL_W = TLB_W + WAY_W + IDX_W;

    logic [SEL_W-1:0] sel;
    assign sel = {rd_tlb_o, rd_way_o, rd_idx_o};

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!inv_valid_o && !rd_en_o));

    p_first_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (sel == '0));

    p_select_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && (sel != {SEL_W{1'b1}})) |=> (sel == $past(sel) + 1'b1));

    p_page_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid_o |-> (inv_addr_o[12:0] == 13'd0));

    p_hold_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid_o && !inv_ready_i) |=> (inv_valid_o && $stable(inv_addr_o)));

    p_no_read_stalled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid_o && !inv_ready_i) |-> !rd_en_o);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_on_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

endmodule

bind pidflush_scan pidflush_scan_chk #(
    .TLB_W (TLB_W),
    .WAY_W (WAY_W),
    .IDX_W (IDX_W),
    .ADDR_W(pidflush_pkg::WORD_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .rd_en_o     (rd_en_o),
    .rd_tlb_o    (rd_tlb_o),
    .rd_way_o    (rd_way_o),
    .rd_idx_o    (rd_idx_o),
    .inv_valid_o (inv_valid_o),
    .inv_ready_i (inv_ready_i),
    .inv_addr_o  (inv_addr_o)
);

// File: tb/tb_pidflush_scan.sv
module tb_pidflush_scan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  pid_i = 8'h00;
    logic        busy_o, done_o, rd_en_o;
    logic        rd_tlb_o;
    logic [1:0]  rd_way_o;
    logic [3:0]  rd_idx_o;
    logic [18:0] ent_vpn_i;
    logic [7:0]  ent_pid_i;
    logic        ent_global_i, ent_valid_i;
    logic        inv_valid_o;
    logic        inv_ready_i = 1'b1;
    logic [31:0] inv_addr_o;

    always #2.5 clk = ~clk;

    logic [18:0] t_vpn [128];
    logic [7:0]  t_pid [128];
    logic        t_glb [128];
    logic        t_vld [128];

    wire [6:0] sel = {rd_tlb_o, rd_way_o, rd_idx_o};
    assign ent_vpn_i    = t_vpn[sel];
    assign ent_pid_i    = t_pid[sel];
    assign ent_global_i = t_glb[sel];
    assign ent_valid_i  = t_vld[sel];

    pidflush_scan dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pid_i(pid_i),
        .busy_o(busy_o), .done_o(done_o), .rd_en_o(rd_en_o),
        .rd_tlb_o(rd_tlb_o), .rd_way_o(rd_way_o), .rd_idx_o(rd_idx_o),
        .ent_vpn_i(ent_vpn_i), .ent_pid_i(ent_pid_i),
        .ent_global_i(ent_global_i), .ent_valid_i(ent_valid_i),
        .inv_valid_o(inv_valid_o), .inv_ready_i(inv_ready_i),
        .inv_addr_o(inv_addr_o)
    );

    int errors = 0;
    int checks = 0;
    int visits = 0;
    int dones  = 0;
    int emitted = 0;
    int ready_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [31:0] expq [$];
    logic        prev_stall = 1'b0;
    logic [31:0] prev_addr = '0;
    logic        finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ready driver, away from the sampling edge
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (ready_mode)
            0: inv_ready_i = 1'b1;
            1: inv_ready_i = ~inv_ready_i;
            default: inv_ready_i = lfsr[0];
        endcase
    end

    // monitor: select order, handshakes, stall hold, done pulses
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_en_o) begin
                chk(sel == visits[6:0], "R3", "entry select order", {25'd0, sel}, visits);
                visits++;
            end
            if (prev_stall) begin
                chk(inv_valid_o && inv_addr_o == prev_addr, "R6", "held request",
                    inv_addr_o, prev_addr);
                chk(!rd_en_o || inv_ready_i, "R6", "no consume while stalled",
                    {31'd0, rd_en_o}, 0);
            end
            if (inv_valid_o && inv_ready_i) begin
                emitted++;
                if (expq.size() == 0) begin
                    chk(1'b0, "R2", "unexpected request", inv_addr_o, 0);
                end else begin
                    logic [31:0] e;
                    e = expq.pop_front();
                    chk(inv_addr_o == e, "R4", "request address", inv_addr_o, e);
                end
            end
            if (done_o) begin
                dones++;
                chk(!busy_o, "R8", "busy low with done", {31'd0, busy_o}, 0);
            end
            prev_stall = inv_valid_o && !inv_ready_i;
            prev_addr  = inv_addr_o;
        end
    end

    task automatic fill(input int seed, input logic [7:0] own, input bit hide);
        for (int e = 0; e < 128; e++) begin
            t_vpn[e] = 19'((e * 2731 + seed * 97) ^ (seed << 5));
            case ((e + seed) % 4)
                0, 1: t_pid[e] = own;
                2:    t_pid[e] = own ^ 8'h01;
                default: t_pid[e] = 8'h3C + 8'(e);
            endcase
            t_vld[e] = ((e + seed) % 3) != 0;
            t_glb[e] = ((e + seed) % 7) == 0;
            if (hide && t_pid[e] == own) begin
                if (e % 2 == 0) t_vld[e] = 1'b0;
                else            t_glb[e] = 1'b1;
            end
        end
    endtask

    task automatic run_scan(input logic [7:0] p, input int mode, input bit poke,
                            input int exp_busy, input string tag);
        int busy_cnt;
        int exp_n;
        busy_cnt = 0;
        exp_n = 0;
        for (int e = 0; e < 128; e++) begin
            if (t_vld[e] && !t_glb[e] && t_pid[e] == p) begin
                expq.push_back({t_vpn[e], 13'd0});
                exp_n++;
            end
        end
        @(negedge clk);
        ready_mode = mode;
        visits = 0; dones = 0; emitted = 0;
        start_i = 1'b1; pid_i = p;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) begin
            if (busy_o) busy_cnt++;
            if (poke && busy_cnt == 20) begin
                start_i = 1'b1; pid_i = p ^ 8'h01;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        chk(dones == 1, "R8", {tag, " single done pulse"}, dones, 1);
        chk(visits == 128, "R5", {tag, " entries consumed"}, visits, 128);
        chk(emitted == exp_n, "R2", {tag, " request count"}, emitted, exp_n);
        chk(expq.size() == 0, "R4", {tag, " missing requests"}, expq.size(), 0);
        chk(!busy_o && !inv_valid_o, "R7", {tag, " idle after scan"},
            {30'd0, busy_o, inv_valid_o}, 0);
        if (exp_busy > 0)
            chk(busy_cnt == exp_busy, "R9", {tag, " busy cycles"}, busy_cnt, exp_busy);
        expq.delete();
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                chk(1'b0, "R8", "watchdog expired", 0, 1);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        join_none
        fill(1, 8'h42, 1'b0);
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(!busy_o && !done_o && !rd_en_o && !inv_valid_o, "R1", "reset outputs",
            {28'd0, busy_o, done_o, rd_en_o, inv_valid_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy_o && !inv_valid_o, "R1", "idle outputs", {30'd0, busy_o, inv_valid_o}, 0);

        // R2 R4 R5: steady ready; a clean scan takes exactly 128 busy cycles only with no
        // stall at the end, so the busy count is checked only in the empty case (R9)
        run_scan(8'h42, 0, 1'b0, 0, "steady");
        // R6: alternating back-pressure
        fill(2, 8'h42, 1'b0);
        run_scan(8'h42, 1, 1'b0, 0, "alternating");
        // R6: pseudo-random back-pressure, another tag
        fill(5, 8'hA7, 1'b0);
        run_scan(8'hA7, 2, 1'b0, 0, "random");
        // R7: start pulse during the scan with a different tag
        fill(3, 8'h42, 1'b0);
        run_scan(8'h42, 2, 1'b1, 0, "restart-ignored");
        // R9: tag only on invalid or global entries
        fill(4, 8'h55, 1'b1);
        run_scan(8'h55, 2, 1'b0, 128, "empty");
        // R9: tag absent everywhere
        run_scan(8'hEE, 0, 1'b0, 128, "absent");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule